// File: doc/BRIEF.md
# Adaptive Run-Length Threshold Gate

This block turns a numeric run-length prediction into a single yes/no customization decision. It compares the prediction with a threshold and asserts the decision when the prediction is strictly greater. The threshold is not fixed. It is picked at run time from a small parameterised list of candidate values. The default list is 0, 100, 1000, 5000 and 10000 instructions.

At the start of every program phase the block enters a sampling pass. Each candidate is put in force for one sampling slot, in ascending index order. A slot lasts a parameterised number of interval ticks. During each slot the block counts the metric events it receives, such as cache hits; a higher count scores better. After the last slot the best-scoring candidate is held until the next phase-change pulse, which starts a new sampling pass.

The prediction and the decision form a pass-through stream with no storage. The decision is valid whenever the prediction is valid. Back-pressure from the decision consumer is handed straight to the prediction producer. A transfer happens on a cycle where both valid and ready are high.

Top module: `runlen_gate_ctrl`

## Requirements
- R1: `dec_customize` is high exactly when the unsigned `pred_len` is greater than the threshold of the candidate at index `active_idx`. This is combinational in the same cycle.
- R2: `dec_valid` equals `pred_valid`, and `pred_ready` equals `dec_ready`, in every cycle. No prediction is stored.
- R3: By default candidate index 0..4 maps to thresholds 0, 100, 1000, 5000 and 10000. `active_idx` always reports the index of the candidate in force and never exceeds NUM_CAND-1.
- R4: After reset `sampling` is 1, `active_idx` is 0 and the metric score is empty. Sampling starts without a phase-change pulse.
- R5: While sampling, each candidate stays in force for exactly SLOT_TICKS ticks (default 3). On the cycle after the slot's last tick, `active_idx` moves up by one.
- R6: The score counts the metric events seen in one slot only and clears at each slot start. Metric events and ticks seen while holding have no effect.
- R7: On the cycle after the last slot's final tick, `sampling` goes to 0 and `active_idx` shows the candidate with the highest count. On a tie the lower index wins.
- R8: While holding, `sampling` stays 0 and `active_idx` stays constant until `phase_chg` is seen.
- R9: A `phase_chg` pulse, whether sampling or holding, discards all scores. On the next cycle the block is sampling from index 0. On the same cycle `phase_chg` takes priority over `tick`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pred_valid | input | 1 | Prediction valid |
| pred_ready | output | 1 | Prediction ready (mirrors dec_ready) |
| pred_len | input | LEN_W | Predicted run length |
| dec_valid | output | 1 | Decision valid (mirrors pred_valid) |
| dec_ready | input | 1 | Decision consumer ready |
| dec_customize | output | 1 | 1 when pred_len exceeds the active threshold |
| phase_chg | input | 1 | One-cycle phase-change pulse |
| metric_evt | input | 1 | One feedback event this cycle |
| tick | input | 1 | Interval tick |
| sampling | output | 1 | 1 while sampling, 0 while holding |
| active_idx | output | IDX_W | Index of the candidate in force |

## Verification
The assertions assume three things about the inputs:
- `phase_chg` is a clean pulse, synchronous to `clk`.
- `tick` and `metric_evt` are plain per-cycle strobes.
- `pred_len` is held steady whenever the decision's stability is judged.

The stimulus keeps within this. It drives every input one time unit after a rising edge and gives each pulse exactly one cycle. It changes `pred_len` only between edges while running the comparison sweeps. It separates metric events from ticks, so the score of each slot is known exactly. The one exception is a deliberate case where a phase pulse lands together with a slot-ending tick.

// File: rtl/runlen_gate_pkg.sv
package runlen_gate_pkg;
  localparam int unsigned DEF_NUM_CAND   = 5;
  localparam int unsigned DEF_LEN_W      = 16;
  localparam int unsigned DEF_MET_W      = 16;
  localparam int unsigned DEF_SLOT_TICKS = 3;

  typedef enum logic {
    MODE_HOLD   = 1'b0,
    MODE_SAMPLE = 1'b1
  } gate_mode_e;
endpackage

// File: rtl/rlg_slot_timer.sv
module rlg_slot_timer #(
  parameter int unsigned SLOT_TICKS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic en,
  input  logic tick,
  output logic slot_end
);
  localparam int unsigned CNT_W = (SLOT_TICKS > 1) ? $clog2(SLOT_TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SLOT_TICKS - 1);

  logic [CNT_W-1:0] cnt;

  assign slot_end = en && tick && !clear && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clear) begin
      cnt <= '0;
    end else if (en && tick) begin
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end

  // R6
  timer_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clear) |=> $stable(cnt));
endmodule

// File: rtl/rlg_best_track.sv
module rlg_best_track #(
  parameter int unsigned MET_W = 16,
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             en,
  input  logic             metric_evt,
  input  logic             slot_end,
  input  logic             first_slot,
  input  logic [IDX_W-1:0] cand_idx,
  output logic [IDX_W-1:0] win_idx
);
  logic [MET_W-1:0] acc;
  logic [MET_W-1:0] best_score;
  logic [IDX_W-1:0] best_idx;
  logic [MET_W-1:0] score_now;
  logic             take;
  logic             count;

  assign count     = en && !clear && metric_evt;
  assign score_now = (count && (acc != '1)) ? acc + 1'b1 : acc;
  assign take      = slot_end && (first_slot || (score_now > best_score));
  assign win_idx   = take ? cand_idx : best_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc        <= '0;
      best_score <= '0;
      best_idx   <= '0;
    end else if (clear) begin
      acc        <= '0;
      best_score <= '0;
      best_idx   <= '0;
    end else if (slot_end) begin
      acc <= '0;
      if (take) begin
        best_score <= score_now;
        best_idx   <= cand_idx;
      end
    end else begin
      acc <= score_now;
    end
  end

  // R6
  hold_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clear) |=> $stable(acc));
endmodule

// File: rtl/rlg_gate.sv
module rlg_gate #(
  parameter int unsigned LEN_W = 16
) (
  input  logic [LEN_W-1:0] pred_len,
  input  logic [LEN_W-1:0] threshold,
  output logic             customize
);
  assign customize = (pred_len > threshold);
endmodule

// File: rtl/runlen_gate_ctrl.sv
module runlen_gate_ctrl
  import runlen_gate_pkg::*;
#(
  parameter int unsigned NUM_CAND   = DEF_NUM_CAND,
  parameter int unsigned LEN_W      = DEF_LEN_W,
  parameter int unsigned MET_W      = DEF_MET_W,
  parameter int unsigned SLOT_TICKS = DEF_SLOT_TICKS,
  parameter logic [NUM_CAND-1:0][LEN_W-1:0] CAND_THR =
    {LEN_W'(10000), LEN_W'(5000), LEN_W'(1000), LEN_W'(100), LEN_W'(0)},
  localparam int unsigned IDX_W = (NUM_CAND > 1) ? $clog2(NUM_CAND) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pred_valid,
  output logic             pred_ready,
  input  logic [LEN_W-1:0] pred_len,
  output logic             dec_valid,
  input  logic             dec_ready,
  output logic             dec_customize,
  input  logic             phase_chg,
  input  logic             metric_evt,
  input  logic             tick,
  output logic             sampling,
  output logic [IDX_W-1:0] active_idx
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CAND - 1);

  gate_mode_e       mode;
  logic [IDX_W-1:0] cand_idx;
  logic [IDX_W-1:0] sel_idx;
  logic [IDX_W-1:0] win_idx;
  logic [LEN_W-1:0] threshold;
  logic             slot_end;
  logic             in_sample;

  assign in_sample  = (mode == MODE_SAMPLE);
  assign sampling   = in_sample;
  assign active_idx = in_sample ? cand_idx : sel_idx;
  assign threshold  = (active_idx <= LAST_IDX) ? CAND_THR[active_idx] : '0;

  assign dec_valid  = pred_valid;
  assign pred_ready = dec_ready;

  rlg_slot_timer #(.SLOT_TICKS(SLOT_TICKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .clear(phase_chg), .en(in_sample),
    .tick(tick), .slot_end(slot_end)
  );

  rlg_best_track #(.MET_W(MET_W), .IDX_W(IDX_W)) u_track (
    .clk(clk), .rst_n(rst_n), .clear(phase_chg), .en(in_sample),
    .metric_evt(metric_evt), .slot_end(slot_end),
    .first_slot(cand_idx == '0), .cand_idx(cand_idx), .win_idx(win_idx)
  );

  rlg_gate #(.LEN_W(LEN_W)) u_gate (
    .pred_len(pred_len), .threshold(threshold), .customize(dec_customize)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode     <= MODE_SAMPLE;
      cand_idx <= '0;
      sel_idx  <= '0;
    end else if (phase_chg) begin
      mode     <= MODE_SAMPLE;
      cand_idx <= '0;
    end else if (in_sample && slot_end) begin
      if (cand_idx == LAST_IDX) begin
        mode    <= MODE_HOLD;
        sel_idx <= win_idx;
      end else begin
        cand_idx <= cand_idx + 1'b1;
      end
    end
  end

  // R3
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_idx <= LAST_IDX);

  // R5
  slot_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sampling && !phase_chg && !tick) |=> $stable(active_idx));

  // R8
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sampling && !phase_chg) |=> (!sampling && $stable(active_idx)));

  // R9
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_chg |=> (sampling && active_idx == '0));

  // R1
  hold_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sampling && !phase_chg && $stable(pred_len)) |=> $stable(dec_customize));
endmodule

// File: tb/runlen_gate_ctrl_tb.sv
`timescale 1ns/1ps
module runlen_gate_ctrl_tb;
  localparam int NC = 5;
  localparam int ST = 3;
  localparam int THR [NC] = '{0, 100, 1000, 5000, 10000};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pred_valid = 1'b0, dec_ready = 1'b0;
  logic [15:0] pred_len = '0;
  logic phase_chg = 1'b0, metric_evt = 1'b0, tick = 1'b0;
  logic pred_ready, dec_valid, dec_customize, sampling;
  logic [2:0] active_idx;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;
  int sc [NC];

  always #2 clk = ~clk;

  runlen_gate_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .pred_valid(pred_valid), .pred_ready(pred_ready),
    .pred_len(pred_len), .dec_valid(dec_valid), .dec_ready(dec_ready),
    .dec_customize(dec_customize), .phase_chg(phase_chg),
    .metric_evt(metric_evt), .tick(tick), .sampling(sampling),
    .active_idx(active_idx)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic pulse_tick();
    tick = 1'b1; step(); tick = 1'b0;
  endtask

  task automatic pulse_phase();
    phase_chg = 1'b1; step(); phase_chg = 1'b0;
  endtask

  task automatic events(input int n);
    for (int k = 0; k < n; k++) begin
      metric_evt = 1'b1; step(); metric_evt = 1'b0;
    end
  endtask

  // R1, R2 comparison and handshake sweep against the candidate in force
  task automatic sweep(input int idx);
    int lens [4];
    lens[0] = THR[idx];
    lens[1] = THR[idx] + 1;
    lens[2] = (THR[idx] > 0) ? THR[idx] - 1 : 0;
    lens[3] = 65535;
    for (int j = 0; j < 4; j++) begin
      pred_len = 16'(lens[j]);
      #0.1;
      chk(dec_customize == (lens[j] > THR[idx]), "R1", dec_customize, lens[j] > THR[idx]);
    end
    for (int v = 0; v < 4; v++) begin
      pred_valid = v[0]; dec_ready = v[1];
      #0.1;
      chk(dec_valid == v[0], "R2 valid", dec_valid, v[0]);
      chk(pred_ready == v[1], "R2 ready", pred_ready, v[1]);
    end
  endtask

  function automatic int best_of();
    int b = 0;
    for (int i = 1; i < NC; i++) if (sc[i] > sc[b]) b = i;
    return b;
  endfunction

  // Runs one full sampling pass (already sampling at idx 0) using sc[]
  task automatic run_pass();
    int win;
    for (int i = 0; i < NC; i++) begin
      chk(sampling == 1'b1, "R5 sampling", sampling, 1);
      chk(active_idx == i, "R5 slot index", active_idx, i);
      sweep(i);
      events(sc[i]);
      for (int t = 0; t < ST - 1; t++) begin
        pulse_tick();
        chk(active_idx == i, "R5 slot length", active_idx, i);
      end
      pulse_tick();
    end
    win = best_of();
    chk(sampling == 1'b0, "R7 hold entry", sampling, 0);
    chk(active_idx == win, "R7 winner", active_idx, win);
    sweep(win);
    // R6 / R8: stimulus while holding has no effect
    events(7);
    for (int t = 0; t < 2 * ST; t++) pulse_tick();
    chk(sampling == 1'b0, "R8 stays held", sampling, 0);
    chk(active_idx == win, "R8 index held", active_idx, win);
  endtask

  initial begin
    #(4.0 * 200000);
    if (!finished) begin
      vectors++; miscompares++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    step(); step();
    rst_n = 1'b1;
    #1;
    // R4 reset state
    chk(sampling == 1'b1, "R4 sampling", sampling, 1);
    chk(active_idx == 0, "R4 index", active_idx, 0);
    // R3 candidate mapping exercised through sweeps; R4 immediate sampling
    sc = '{0, 0, 0, 0, 0}; run_pass();        // all tie -> 0
    pulse_phase();
    chk(sampling && active_idx == 0, "R9 restart from hold", active_idx, 0);
    sc = '{1, 3, 2, 3, 0}; run_pass();        // tie -> 1
    pulse_phase();
    sc = '{0, 0, 0, 0, 4}; run_pass();        // last wins
    pulse_phase();
    sc = '{2, 1, 0, 0, 2}; run_pass();        // R6 per-slot clear -> 0
    // R9 restart mid-sampling: big scores in early slots discarded
    pulse_phase();
    events(5); for (int t = 0; t < ST; t++) pulse_tick();
    events(5); for (int t = 0; t < ST; t++) pulse_tick();
    chk(active_idx == 2, "R5 advance", active_idx, 2);
    events(1);
    pulse_phase();
    chk(sampling && active_idx == 0, "R9 restart mid", active_idx, 0);
    sc = '{1, 2, 0, 0, 0}; run_pass();        // -> 1
    // R9 phase pulse together with slot-ending tick
    pulse_phase();
    events(3);
    for (int t = 0; t < ST - 1; t++) pulse_tick();
    tick = 1'b1; phase_chg = 1'b1; step(); tick = 1'b0; phase_chg = 1'b0;
    chk(active_idx == 0, "R9 priority over tick", active_idx, 0);
    sc = '{0, 1, 0, 2, 2}; run_pass();        // -> 3
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule